// File: doc/BRIEF.md
# Multichannel Conversion Result Sequencer

This block shares one converter between four input channels and keeps the newest 10-bit result for each. On every converter-clock enable pulse it advances a slot counter. Each slot lasts twelve converter clocks: ten for conversion and two for settling. On the last clock of a slot it stores the converter's output for the channel being served, then moves to the next enabled channel in ascending order, wrapping from channel 4 back to channel 1.

A host drives the block through a byte-wide command port. Within a frame, the first byte written is an address/command byte. It is followed by data bytes written or read one at a time. A control register holds:
- a converter power bit,
- a run bit,
- one enable bit per channel.

The intended use is to let the sequencer run, clear the run bit so every held result freezes, read the results as two bytes each, and then set the run bit again. Reading a result while the run bit is high still works, but it leaves a sticky warning flag in a status byte.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, all four results read as zero, the control register is zero, `cnv_busy` is low, `cnv_div` is zero and the status byte is zero.
- R2: Results are read at addresses 0xDC, 0xDD, 0xDE and 0xDF for channels 1 to 4. The first read byte holds result bits 7..0. The second read byte holds result bits 9..8 in its bits 1..0, and its bits 7..2 are zero.
- R3: A slot lasts exactly 12 converter-clock pulses. The converter output is stored into the served channel's result on the 12th pulse, and not before.
- R4: The control register is at address 0xD7. Its bit layout is:
  - bit 6: converter power.
  - bit 5: run.
  - bits 4, 3, 2 and 1: enables for channels 1, 2, 3 and 4.
  
  `cnv_busy` is high only when power, run and at least one enable are all set. With power low, no result changes.
- R5: Every write to the control register restarts the sequence at the lowest-numbered enabled channel with a fresh slot. Enabled channels are then served in ascending order with wrap-around. Disabled channels are skipped and keep their results. While busy, `cnv_ch` names the channel being served (0 for channel 1 to 3 for channel 4).
- R6: While the run bit is low, no stored result changes, whatever converter pulses arrive.
- R7: A one-byte read at address 0xD9 returns the status byte, whose bit 0 is the unsafe-read flag. The flag is set by a result read made while the run bit is high, and it stays set until a general reset. Such a read returns the current held value.
- R8: A frame whose address byte is 0x01 performs a general reset. It clears the results, the control register, the divider register and the flag.
- R9: The single data byte written to address 0xD0 appears on `cnv_div`.
- R10: Only the first data byte after the address in a frame takes effect, and later write bytes are ignored. Each read strobe returns its byte on `host_rbyte` with `host_rvalid` high in the following cycle. Deasserting `host_sel` ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_tick | input | 1 | One-cycle pulse per converter clock |
| cnv_result | input | 10 | Converter output for the channel on `cnv_ch` |
| cnv_ch | output | 2 | Channel currently being converted |
| cnv_busy | output | 1 | Sequencer is converting |
| cnv_div | output | 8 | Converter clock divider setting |
| host_sel | input | 1 | Frame select, high for the whole transaction |
| host_we | input | 1 | Write strobe for `host_wbyte` |
| host_wbyte | input | 8 | Address/command or data byte |
| host_re | input | 1 | Read strobe |
| host_rbyte | output | 8 | Read byte, valid with `host_rvalid` |
| host_rvalid | output | 1 | Read byte valid, one cycle after the strobe |

## Verification
The sequencer is swept over every one of the fifteen non-empty enable masks. For each mask it is run for every whole number of slots from zero to five, which is more than one full lap. Each run stops either exactly on a slot boundary or eleven pulses past it. That separates:
- the 12-pulse slot length from an off-by-one;
- the ascending wrap-around order from any other visiting order;
- skipped channels from channels that were served.

The converter output seen by the bench changes with each run and each channel. As a result, a stale value, a value written to the wrong channel, and a dropped upper byte all show up as distinct mismatches. Further patterns cover:
- pulses applied while frozen;
- pulses applied with converter power off;
- extra trailing data bytes in a frame;
- a result read while running, and the sticky flag it leaves;
- the general-reset command.

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int         RES_W        = 10,
  parameter int         CONV_TICKS   = 10,
  parameter int         SETTLE_TICKS = 2,
  parameter logic [7:0] A_RESET      = 8'h01,
  parameter logic [7:0] A_DIV        = 8'hD0,
  parameter logic [7:0] A_CTRL       = 8'hD7,
  parameter logic [7:0] A_STAT       = 8'hD9,
  parameter logic [7:0] A_RES0       = 8'hDC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_tick,
  input  logic [RES_W-1:0] cnv_result,
  output logic [1:0]       cnv_ch,
  output logic             cnv_busy,
  output logic [7:0]       cnv_div,
  input  logic             host_sel,
  input  logic             host_we,
  input  logic [7:0]       host_wbyte,
  input  logic             host_re,
  output logic [7:0]       host_rbyte,
  output logic             host_rvalid
);
  localparam int NCH  = 4;
  localparam int CW   = $clog2(NCH);
  localparam int SLOT = CONV_TICKS + SETTLE_TICKS;
  localparam int SW   = $clog2(SLOT);

  function automatic logic [NCH-1:0] en_of(input logic [7:0] c);
    return {c[1], c[2], c[3], c[4]};
  endfunction

  function automatic logic [CW-1:0] next_en(input logic [NCH-1:0] e, input logic [CW-1:0] c);
    logic [CW-1:0] r;
    logic [CW-1:0] idx;
    r = c;
    for (int k = NCH; k >= 1; k--) begin
      idx = c + CW'(k);
      if (e[idx]) r = idx;
    end
    return r;
  endfunction

  logic [NCH-1:0][RES_W-1:0] res_q;
  logic [7:0]    ctrl_q, div_q, addr_q, rd_byte;
  logic [SW-1:0] slot_q;
  logic [CW-1:0] cur_q;
  logic [1:0]    wcnt_q;
  logic          rcnt_q, have_addr_q, unsafe_q;
  logic [NCH-1:0] en;
  logic          active, wr_go, addr_go, data_go, gclr, ctrl_wr, div_wr, rd_go, rd_res;
  logic [15:0]   sel_res;

  assign en      = en_of(ctrl_q);
  assign active  = ctrl_q[6] & ctrl_q[5] & (|en);
  assign wr_go   = host_sel & host_we;
  assign addr_go = wr_go & ~have_addr_q;
  assign data_go = wr_go & have_addr_q & (wcnt_q == 2'd0);
  assign gclr    = addr_go & (host_wbyte == A_RESET);
  assign ctrl_wr = data_go & (addr_q == A_CTRL);
  assign div_wr  = data_go & (addr_q == A_DIV);
  assign rd_go   = host_sel & host_re & ~host_we & have_addr_q;
  assign rd_res  = rd_go & (addr_q[7:CW] == A_RES0[7:CW]);
  assign sel_res = 16'(res_q[addr_q[CW-1:0]]);

  assign cnv_ch   = cur_q;
  assign cnv_busy = active;
  assign cnv_div  = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_addr_q <= 1'b0;
      addr_q      <= '0;
      wcnt_q      <= '0;
      rcnt_q      <= 1'b0;
    end else if (!host_sel) begin
      have_addr_q <= 1'b0;
      wcnt_q      <= '0;
      rcnt_q      <= 1'b0;
    end else begin
      if (addr_go) begin
        have_addr_q <= 1'b1;
        addr_q      <= host_wbyte;
      end
      if (wr_go && have_addr_q && wcnt_q != 2'd3) wcnt_q <= wcnt_q + 2'd1;
      if (rd_go) rcnt_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      div_q    <= '0;
      res_q    <= '0;
      slot_q   <= '0;
      cur_q    <= '0;
      unsafe_q <= 1'b0;
    end else if (gclr) begin
      ctrl_q   <= '0;
      div_q    <= '0;
      res_q    <= '0;
      slot_q   <= '0;
      cur_q    <= '0;
      unsafe_q <= 1'b0;
    end else begin
      if (div_wr) div_q <= host_wbyte;
      if (rd_res && ctrl_q[5]) unsafe_q <= 1'b1;
      if (ctrl_wr) begin
        ctrl_q <= host_wbyte;
        slot_q <= '0;
        cur_q  <= next_en(en_of(host_wbyte), CW'(NCH - 1));
      end else if (!active) begin
        slot_q <= '0;
        cur_q  <= next_en(en, CW'(NCH - 1));
      end else if (cnv_tick) begin
        if (slot_q == SW'(SLOT - 1)) begin
          res_q[cur_q] <= cnv_result;
          slot_q       <= '0;
          cur_q        <= next_en(en, cur_q);
        end else begin
          slot_q <= slot_q + SW'(1);
        end
      end
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (addr_q[7:CW] == A_RES0[7:CW])
      rd_byte = rcnt_q ? sel_res[15:8] : sel_res[7:0];
    else if (addr_q == A_STAT && !rcnt_q)
      rd_byte = {7'b0, unsafe_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rbyte  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd_go;
      if (rd_go) host_rbyte <= rd_byte;
    end
  end

  p_slot_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q != $past(res_q)) |-> ($past(cnv_tick && slot_q == SW'(SLOT - 1)) || $past(gclr)));
  p_slot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < SW'(SLOT));
  p_serve_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_busy |-> en[cnv_ch]);
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[5] && !gclr) |=> $stable(res_q));
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (unsafe_q && !gclr) |=> unsafe_q);
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && ctrl_q[5]) |=> unsafe_q);
  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> host_rvalid);
endmodule

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
  logic       clk = 1'b0, rst_n = 1'b0, cnv_tick = 1'b0;
  logic [9:0] cnv_result;
  logic [1:0] cnv_ch;
  logic       cnv_busy, host_sel = 1'b0, host_we = 1'b0, host_re = 1'b0, host_rvalid;
  logic [7:0] cnv_div, host_wbyte = '0, host_rbyte;
  int checks = 0, errors = 0, phase = 0;
  int expv[4];

  always #2.5 clk = ~clk;

  function automatic logic [9:0] val(input int ch, input int ph);
    return 10'((ph * 53 + ch * 211 + 7) & 1023);
  endfunction

  assign cnv_result = val(int'(cnv_ch), phase);

  conv_sequencer u_conv_sequencer (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cnv_tick = 1'b1;
      @(negedge clk) cnv_tick = 1'b0;
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d, input int extra);
    @(negedge clk) begin host_sel = 1'b1; host_we = 1'b1; host_wbyte = a; end
    @(negedge clk) host_wbyte = d;
    for (int i = 0; i < extra; i++) @(negedge clk) host_wbyte = 8'h00;
    @(negedge clk) begin host_we = 1'b0; host_sel = 1'b0; end
  endtask

  task automatic host_cmd(input logic [7:0] a);
    @(negedge clk) begin host_sel = 1'b1; host_we = 1'b1; host_wbyte = a; end
    @(negedge clk) begin host_we = 1'b0; host_sel = 1'b0; end
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] b0, output logic [7:0] b1, output logic v);
    @(negedge clk) begin host_sel = 1'b1; host_we = 1'b1; host_wbyte = a; end
    @(negedge clk) begin host_we = 1'b0; host_re = 1'b1; end
    @(negedge clk) begin b0 = host_rbyte; v = host_rvalid; end
    @(negedge clk) begin b1 = host_rbyte; host_re = 1'b0; host_sel = 1'b0; end
  endtask

  task automatic check_all(input string tag);
    logic [7:0] b0, b1;
    logic v;
    for (int c = 0; c < 4; c++) begin
      host_read(8'hDC + 8'(c), b0, b1, v);
      check(tag, int'({b1, b0}), expv[c]);
    end
  endtask

  task automatic status(input string tag, input int exp);
    logic [7:0] b0, b1;
    logic v;
    host_read(8'hD9, b0, b1, v);
    check(tag, int'(b0), exp);
  endtask

  function automatic logic [7:0] ctrl_of(input logic [3:0] m, input logic run);
    return {1'b0, 1'b1, run, m[0], m[1], m[2], m[3], 1'b0};
  endfunction

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b0, b1;
    logic v;
    for (int c = 0; c < 4; c++) expv[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(cnv_busy), 0);
    check("R1 div after reset", int'(cnv_div), 0);
    status("R1 status after reset", 0);
    check_all("R1 results after reset");

    for (int m = 1; m < 16; m++) begin
      for (int k = 0; k <= 5; k++) begin
        for (int e = 0; e < 2; e++) begin
          int c;
          phase++;
          host_write(8'hD7, ctrl_of(4'(m), 1'b1), 0);
          ticks(k * 12 + e * 11);
          host_write(8'hD7, ctrl_of(4'(m), 1'b0), 0);
          c = 0;
          while (!m[c]) c++;
          for (int s = 0; s < k; s++) begin
            expv[c] = int'(val(c, phase));
            c = (c + 1) % 4;
            while (!m[c]) c = (c + 1) % 4;
          end
          check_all("R2 R3 R5 sweep result");
        end
      end
      phase++;
      ticks(30);
      check_all("R6 frozen results unchanged");
    end

    phase++;
    host_write(8'hD7, 8'h3E, 0);
    check("R4 busy with power off", int'(cnv_busy), 0);
    ticks(30);
    host_write(8'hD7, 8'h1E, 0);
    check_all("R4 no update with power off");

    host_write(8'hD7, 8'h70, 2);
    check("R10 extra bytes ignored busy", int'(cnv_busy), 1);
    check("R5 starts at channel 1", int'(cnv_ch), 0);
    host_write(8'hD7, 8'h6A, 0);
    check("R5 starts at lowest enabled", int'(cnv_ch), 1);

    status("R7 flag clear before unsafe read", 0);
    host_read(8'hDC, b0, b1, v);
    check("R10 read valid next cycle", int'(v), 1);
    check("R7 unsafe read returns held value", int'({b1, b0}), expv[0]);
    status("R7 flag set by unsafe read", 1);
    host_write(8'hD7, 8'h5E, 0);
    status("R7 flag sticky after freeze", 1);

    host_write(8'hD0, 8'h03, 0);
    check("R9 divider written", int'(cnv_div), 3);

    host_cmd(8'h01);
    for (int c = 0; c < 4; c++) expv[c] = 0;
    check("R8 div cleared", int'(cnv_div), 0);
    check("R8 busy cleared", int'(cnv_busy), 0);
    status("R8 flag cleared", 0);
    ticks(30);
    check_all("R8 results cleared and control idle");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule